// File: doc/BRIEF.md
# Configuration Command Frame Receiver

This block sits behind a UART receiver and listens for short configuration commands. Bytes arrive one at a time with a valid strobe. Until a start marker arrives, every byte is dropped. After the start marker the block collects a fixed body of five bytes. A free-running microsecond tick times the gap between those bytes, and a stall that lasts too long abandons the frame.

Once the sixth byte arrives, the block runs a CRC16 over the whole frame, including the two received check bytes. The frame is good only when the residue is zero. A good frame loads two setup registers and a rate register together in one clock. A bad or abandoned frame leaves all three registers as they were. In both cases a one-cycle status pulse reports the outcome.

The block also scales the stored rate by a power of ten, chosen by two bits of the first setup register, to give a sample rate in hertz.

Top module: `cmd_frame_rx`

## Requirements
- R1: After reset, `setup_a`, `setup_b`, `rate_val` and `rate_hz` are zero, and `frame_ok` and `frame_bad` are low.
- R2: While no frame is open, a valid byte other than the start value `SOF_VAL` (default 0x01) has no effect: no pulse, and all registers stay unchanged.
- R3: After the start byte, exactly five more valid bytes make up the frame, in this order: setup A, setup B, rate, CRC low byte, CRC high byte. A byte equal to `SOF_VAL` inside the body is treated as data.
- R4: The frame is accepted when CRC16 over all six bytes leaves a residue of zero. The CRC has preset 0xFFFF and reflected polynomial 0xA001, each byte enters least significant bit first, and the CRC bytes follow the data, low byte first. On acceptance all three registers load on the clock edge that takes the sixth byte, and `frame_ok` is high for exactly the following cycle.
- R5: A frame whose residue is non-zero leaves all registers unchanged, and `frame_bad` is high for exactly one cycle, timed the same way as `frame_ok`.
- R6: Inside an open frame, the tick count since the last byte may reach `GAP_LIMIT` without effect. The tick that would take the count past `GAP_LIMIT` abandons the frame: `frame_bad` pulses for one cycle and the receiver returns to waiting for a start byte. A byte and a tick in the same cycle count as a byte.
- R7: `rate_hz` equals `rate_val` times 1, 10, 100 or 1000 when `setup_a[1:0]` is 00, 01, 10 or 11. For example, a rate of 100 with code 01 gives 1000.
- R8: Bit 7 of `setup_b` is reserved and always reads zero, even when the frame carries a one in that bit.
- R9: `frame_ok` and `frame_bad` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| rx_valid | input | 1 | `rx_byte` holds a new byte this cycle |
| rx_byte | input | 8 | Received byte |
| setup_a | output | 8 | Setup register A; bits [1:0] select the rate multiplier |
| setup_b | output | 8 | Setup register B; bit 7 reads zero |
| rate_val | output | 8 | Stored rate byte |
| rate_hz | output | 20 | Derived sample rate |
| frame_ok | output | 1 | One-cycle pulse: frame accepted |
| frame_bad | output | 1 | One-cycle pulse: frame rejected or abandoned |

## Verification
The bench builds the block with `GAP_LIMIT` set to 20 instead of 1500. This keeps the gap limit within reach, and both a gap of exactly 20 ticks and a gap of 21 ticks are exercised. The start value keeps its default of 0x01, so a 0x01 placed in a body field shows that the receiver does not restart mid-frame. All four multiplier codes are used, including the largest product, 255 × 1000.

// File: rtl/cfr_pkg.sv
package cfr_pkg;

  localparam int BYTE_W     = 8;
  localparam int CRC_W      = 16;
  localparam int BODY_BYTES = 5;
  localparam int IDX_W      = $clog2(BODY_BYTES + 1);
  localparam int RATE_OUT_W = 20;
  localparam logic [CRC_W-1:0] CRC_SEED = 16'hFFFF;
  localparam logic [CRC_W-1:0] CRC_POLY = 16'hA001;

  typedef enum logic [0:0] {
    ST_HUNT = 1'b0,
    ST_BODY = 1'b1
  } rx_state_e;

  // One byte through the reflected CRC16, LSB first.
  function automatic logic [CRC_W-1:0] crc_byte(
    input logic [CRC_W-1:0]  acc,
    input logic [BYTE_W-1:0] din
  );
    logic [CRC_W-1:0] c;
    c = acc ^ {{(CRC_W-BYTE_W){1'b0}}, din};
    for (int b = 0; b < BYTE_W; b++) begin
      c = c[0] ? ((c >> 1) ^ CRC_POLY) : (c >> 1);
    end
    return c;
  endfunction

endpackage

// File: rtl/cfr_gap_timer.sv
module cfr_gap_timer #(
  parameter int LIMIT = 1500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic tick,
  output logic expired
);
  localparam int CNT_W = $clog2(LIMIT + 1) + 1;
  localparam logic [CNT_W-1:0] LIM_V = CNT_W'(LIMIT);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    expired = tick && !clear && (cnt_q == LIM_V);
    cnt_en  = clear || tick;
    if (clear || expired) cnt_d = '0;
    else                  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R6: the count never runs past the limit
  a_r6_gap_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIM_V);

endmodule

// File: rtl/cfr_crc_acc.sv
module cfr_crc_acc
  import cfr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              adv,
  input  logic [BYTE_W-1:0] din,
  output logic [CRC_W-1:0]  crc_nxt
);
  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] base;
  logic             crc_en;

  always_comb begin
    base    = start ? CRC_SEED : crc_q;
    crc_nxt = crc_byte(base, din);
    crc_en  = start || adv;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc_q <= CRC_SEED;
    else if (crc_en) crc_q <= crc_nxt;
  end

  // R3: seeding and advancing never coincide
  a_r3_seed_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(start && adv));

endmodule

// File: rtl/cfr_rate_scale.sv
module cfr_rate_scale
  import cfr_pkg::*;
(
  input  logic [BYTE_W-1:0]     rate,
  input  logic [1:0]            code,
  output logic [RATE_OUT_W-1:0] hz
);
  logic [RATE_OUT_W-1:0] wide;
  logic [RATE_OUT_W-1:0] mult;

  always_comb begin
    wide = {{(RATE_OUT_W-BYTE_W){1'b0}}, rate};
    unique case (code)
      2'b00:   mult = RATE_OUT_W'(1);
      2'b01:   mult = RATE_OUT_W'(10);
      2'b10:   mult = RATE_OUT_W'(100);
      default: mult = RATE_OUT_W'(1000);
    endcase
    hz = wide * mult;
  end

endmodule

// File: rtl/cmd_frame_rx.sv
module cmd_frame_rx
  import cfr_pkg::*;
#(
  parameter logic [7:0] SOF_VAL   = 8'h01,
  parameter int         GAP_LIMIT = 1500
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        us_tick,
  input  logic        rx_valid,
  input  logic [7:0]  rx_byte,
  output logic [7:0]  setup_a,
  output logic [7:0]  setup_b,
  output logic [7:0]  rate_val,
  output logic [19:0] rate_hz,
  output logic        frame_ok,
  output logic        frame_bad
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BODY_BYTES - 1);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  rx_state_e        state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [7:0]       cap_a_q, cap_b_q, cap_r_q;
  logic             cap_a_en, cap_b_en, cap_r_en;
  logic [7:0]       set_a_q, set_b_q, rate_q;
  logic             ok_q, bad_q;
  logic             commit, reject;
  logic             crc_start, crc_adv;
  logic [CRC_W-1:0] crc_nxt;
  logic             tmr_clr, tmr_exp;

  cfr_crc_acc u_crc (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .start   (crc_start),
    .adv     (crc_adv),
    .din     (rx_byte),
    .crc_nxt (crc_nxt)
  );

  cfr_gap_timer #(.LIMIT(GAP_LIMIT)) u_gap (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .clear   (tmr_clr),
    .tick    (us_tick),
    .expired (tmr_exp)
  );

  cfr_rate_scale u_scale (
    .rate (rate_q),
    .code (set_a_q[1:0]),
    .hz   (rate_hz)
  );

  // next-state logic
  always_comb begin
    state_d   = state_q;
    idx_d     = idx_q;
    commit    = 1'b0;
    reject    = 1'b0;
    crc_start = 1'b0;
    crc_adv   = 1'b0;
    tmr_clr   = 1'b1;
    cap_a_en  = 1'b0;
    cap_b_en  = 1'b0;
    cap_r_en  = 1'b0;
    unique case (state_q)
      ST_HUNT: begin
        if (rx_valid && (rx_byte == SOF_VAL)) begin
          state_d   = ST_BODY;
          idx_d     = '0;
          crc_start = 1'b1;
        end
      end
      default: begin
        tmr_clr = rx_valid;
        if (rx_valid) begin
          crc_adv  = 1'b1;
          idx_d    = idx_q + 1'b1;
          cap_a_en = (idx_q == IDX_W'(0));
          cap_b_en = (idx_q == IDX_W'(1));
          cap_r_en = (idx_q == IDX_W'(2));
          if (idx_q == LAST_IDX) begin
            state_d = ST_HUNT;
            if (crc_nxt == '0) commit = 1'b1;
            else               reject = 1'b1;
          end
        end else if (tmr_exp) begin
          state_d = ST_HUNT;
          reject  = 1'b1;
        end
      end
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= ST_HUNT;
      idx_q   <= '0;
      ok_q    <= 1'b0;
      bad_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      ok_q    <= commit;
      bad_q   <= reject;
    end
  end

  // capture registers for body fields
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      cap_a_q <= '0;
      cap_b_q <= '0;
      cap_r_q <= '0;
    end else begin
      if (cap_a_en) cap_a_q <= rx_byte;
      if (cap_b_en) cap_b_q <= rx_byte;
      if (cap_r_en) cap_r_q <= rx_byte;
    end
  end

  // architectural registers, loaded together on commit
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      set_a_q <= '0;
      set_b_q <= '0;
      rate_q  <= '0;
    end else if (commit) begin
      set_a_q <= cap_a_q;
      set_b_q <= {1'b0, cap_b_q[6:0]};
      rate_q  <= cap_r_q;
    end
  end

  assign setup_a   = set_a_q;
  assign setup_b   = set_b_q;
  assign rate_val  = rate_q;
  assign frame_ok  = ok_q;
  assign frame_bad = bad_q;

  a_r9_pulse_excl: assert property (@(posedge clk) disable iff (!rst_i_n)
    !(ok_q && bad_q));

  a_r8_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_i_n)
    !set_b_q[7]);

  a_r5_hold_on_reject: assert property (@(posedge clk) disable iff (!rst_i_n)
    bad_q |-> ($stable(set_a_q) && $stable(set_b_q) && $stable(rate_q)));

  a_r4_ok_after_byte: assert property (@(posedge clk) disable iff (!rst_i_n)
    ok_q |-> $past(rx_valid));

  a_r2_hunt_ignore: assert property (@(posedge clk) disable iff (!rst_i_n)
    (state_q == ST_HUNT && rx_valid && rx_byte != SOF_VAL) |=> (state_q == ST_HUNT));

endmodule

// File: tb/cmd_frame_rx_tb.sv
module cmd_frame_rx_tb;
  localparam int GAP = 20;

  logic        clk;
  logic        rst_n;
  logic        us_tick;
  logic        rx_valid;
  logic [7:0]  rx_byte;
  logic [7:0]  setup_a, setup_b, rate_val;
  logic [19:0] rate_hz;
  logic        frame_ok, frame_bad;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  cmd_frame_rx #(.SOF_VAL(8'h01), .GAP_LIMIT(GAP)) u_dut (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .setup_a(setup_a), .setup_b(setup_b),
    .rate_val(rate_val), .rate_hz(rate_hz), .frame_ok(frame_ok),
    .frame_bad(frame_bad)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  // ---------------- behavioural reference ----------------
  bit       m_open;
  int       m_gap;
  byte unsigned m_q[$];
  int       m_a, m_b, m_r;
  bit       m_ok, m_bad;

  function automatic int ref_crc(input byte unsigned d[$]);
    int c = 'hFFFF;
    foreach (d[i]) begin
      c = c ^ d[i];
      for (int k = 0; k < 8; k++) c = (c & 1) ? ((c >> 1) ^ 'hA001) : (c >> 1);
    end
    return c;
  endfunction

  function automatic int pow10(input int code);
    int p = 1;
    for (int k = 0; k < code; k++) p = p * 10;
    return p;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_open = 0; m_gap = 0; m_q.delete();
      m_a = 0; m_b = 0; m_r = 0; m_ok = 0; m_bad = 0;
    end else begin
      m_ok = 0; m_bad = 0;
      if (m_open) begin
        if (rx_valid) begin
          m_q.push_back(rx_byte);
          m_gap = 0;
          if (m_q.size() == 6) begin
            if (ref_crc(m_q) == 0) begin
              m_a = m_q[1]; m_b = m_q[2] & 'h7F; m_r = m_q[3]; m_ok = 1;
            end else m_bad = 1;
            m_open = 0; m_q.delete();
          end
        end else if (us_tick) begin
          if (m_gap == GAP) begin m_bad = 1; m_open = 0; m_q.delete(); end
          else m_gap++;
        end
      end else if (rx_valid && rx_byte == 8'h01) begin
        m_open = 1; m_gap = 0; m_q.delete(); m_q.push_back(rx_byte);
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // every-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R4 setup_a", setup_a, m_a);
      chk("R8 setup_b", setup_b, m_b);
      chk("R4 rate_val", rate_val, m_r);
      chk("R7 rate_hz", rate_hz, m_r * pow10(m_a & 3));
      chk("R4 frame_ok", frame_ok, m_ok);
      chk("R5 frame_bad", frame_bad, m_bad);
      chk("R9 pulse exclusive", frame_ok & frame_bad, 0);
    end
  end

  // ---------------- stimulus ----------------
  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk) us_tick = 1;
      @(negedge clk) us_tick = 0;
    end
  endtask

  task automatic send(input byte unsigned b);
    @(negedge clk) begin rx_valid = 1; rx_byte = b; end
    @(negedge clk) rx_valid = 0;
  endtask

  task automatic frame(input byte unsigned a, input byte unsigned b,
                       input byte unsigned r, input bit corrupt);
    byte unsigned q[$];
    int c;
    q = '{8'h01, a, b, r};
    c = ref_crc(q);
    if (corrupt) c = c ^ 'h0100;
    send(8'h01); send(a); send(b); send(r);
    send(8'(c & 'hFF)); send(8'((c >> 8) & 'hFF));
  endtask

  initial begin
    #4000000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; us_tick = 0; rx_valid = 0; rx_byte = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 setup_a", setup_a, 0);
    chk("R1 rate_hz", rate_hz, 0);
    chk("R1 pulses", {frame_ok, frame_bad}, 0);

    // R2 noise while hunting
    send(8'h55); send(8'hFF); send(8'h00); send(8'h02);
    chk("R2 no pulse", {frame_ok, frame_bad}, 0);
    chk("R2 setup_a", setup_a, 0);

    // R4/R7 good frame, code 01 rate 100
    frame(8'h01, 8'h3C, 8'd100, 0);
    chk("R4 frame_ok", frame_ok, 1);
    chk("R7 rate 1000", rate_hz, 1000);
    chk("R3 sof as data", setup_a, 8'h01);

    // R8 reserved bit, R7 x1000 max
    frame(8'h03, 8'hFF, 8'd255, 0);
    chk("R8 bit7", setup_b, 8'h7F);
    chk("R7 rate 255000", rate_hz, 255000);
    frame(8'h00, 8'h11, 8'd7, 0);
    chk("R7 x1", rate_hz, 7);
    frame(8'h02, 8'h80, 8'd42, 0);
    chk("R7 x100", rate_hz, 4200);

    // R5 corrupt CRC
    frame(8'h01, 8'h22, 8'd9, 1);
    chk("R5 frame_bad", frame_bad, 1);
    chk("R5 rate held", rate_hz, 4200);

    // R6 gap exactly GAP tolerated
    send(8'h01); send(8'h01); ticks(GAP);
    begin
      byte unsigned q[$];
      int c;
      q = '{8'h01, 8'h01, 8'h05, 8'd50};
      c = ref_crc(q);
      send(8'h05); send(8'd50); send(8'(c & 'hFF)); send(8'((c >> 8) & 'hFF));
    end
    chk("R6 boundary ok", frame_ok, 1);
    chk("R6 rate 500", rate_hz, 500);

    // R6 gap of GAP+1 abandons
    send(8'h01); send(8'h02);
    ticks(GAP);
    @(negedge clk) us_tick = 1;
    @(negedge clk) us_tick = 0;
    chk("R6 timeout bad", frame_bad, 1);
    send(8'h07); send(8'h09);
    chk("R6 rest ignored", setup_a, 8'h01);

    // R3 restart after timeout
    frame(8'h01, 8'h10, 8'd12, 0);
    chk("R3 after restart", rate_hz, 120);

    repeat (5) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule